// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port in the IEEE 1149.1 style. Four wires (test clock, mode select, serial data in and serial data out) walk a sixteen-state controller, load a three-bit instruction, and move data through one of three data registers. The registers are a single bypass bit, a 32-bit identification word and a boundary register whose length is a parameter. The boundary register has a parallel capture port fed from the pad ring and a parallel update port that drives the pads. Two further outputs let the pads be driven from the update register, or force the data pads to high impedance.

There is no dedicated test-reset pin. The controller reaches its reset state either from the power-up reset or by holding the mode-select line high for five test-clock rising edges. In that state the identification instruction becomes current. Inputs are taken on the rising test-clock edge, and serial output changes only on the falling edge.

Top module: `jtag_port`

## Requirements
- R1: The controller follows the sixteen-state 1149.1 transition graph on each rising `tck` edge, including the Pause and Exit2 loops, and shifting resumes correctly after a pause.
- R2: Asserting `por_n` low, or holding `tms` high for five rising `tck` edges from any state, puts the controller in Test-Logic-Reset.
- R3: While the controller is in Test-Logic-Reset, the current instruction becomes IDCODE (3'b001).
- R4: In Capture-IR the instruction shift stage loads 3'b001, which shifts out LSB first. A new code takes effect only at Update-IR. The codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD and 111 BYPASS. The codes 011, 101 and 110 behave as BYPASS.
- R5: Under IDCODE, Capture-DR loads {ID_REV[3:0], ID_PART[15:0], ID_VENDOR[10:0], 1'b1}. This word is shifted out LSB first.
- R6: Under BYPASS or a reserved code, the data path is one bit. It captures 0 and delays `tdi` by one shift.
- R7: Under EXTEST, SAMPLE/PRELOAD or SAMPLE-Z, Capture-DR loads `pin_sample_i` into the boundary register. Bit 0 is the bit nearest `tdo`.
- R8: At Update-DR under EXTEST or SAMPLE/PRELOAD, the shifted boundary contents appear on `pin_drive_o`. At all other times `pin_drive_o` holds its value.
- R9: `pin_drive_en` is 1 exactly while EXTEST is the current instruction.
- R10: `pin_hiz` is 1 exactly while SAMPLE-Z is the current instruction.
- R11: `tdo` and `tdo_en` change only on the falling `tck` edge. `tdo_en` is 1 only in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous assert |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Serial output valid (shift states only) |
| pin_sample_i | input | BND_LEN | Pad values captured into the boundary register |
| pin_drive_o | output | BND_LEN | Boundary update register toward the pads |
| pin_drive_en | output | 1 | Pads driven from `pin_drive_o` (EXTEST) |
| pin_hiz | output | 1 | Force data pads to high impedance (SAMPLE-Z) |

## Verification
The assertions assume that `tms` and `tdi` are settled around each rising `tck` edge. They also assume that `pin_sample_i` does not change during a Capture-DR edge. The bench meets these conditions by changing every input one nanosecond after a rising edge and sampling `tdo` two nanoseconds after a falling edge. The pad vector is set only while the controller sits in Run-Test/Idle. Each expected serial bit is queued just before the edge that shifts it, so every `tdo_en` cycle is paired with exactly one prediction.

// File: rtl/jtag_pkg.sv
package jtag_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PSE_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PSE_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [OP_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [OP_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [OP_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [OP_W-1:0] OP_BYPASS  = 3'b111;

  localparam logic [OP_W-1:0] OP_CAPTURE_PATTERN = 3'b001;

endpackage

// File: rtl/jtag_fsm.sv
module jtag_fsm
  import jtag_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PSE_DR;
      ST_PSE_DR: state_d = tms ? ST_EX2_DR : ST_PSE_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PSE_IR;
      ST_PSE_IR: state_d = tms ? ST_EX2_IR : ST_PSE_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  // Run length of consecutive high tms samples, saturating at five.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)           tms_run <= 3'd0;
    else if (!tms)        tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run == 3'd5) |-> (state == ST_RESET)); // R2

  AST_SHIFT_DR_ENTRY: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_SH_DR) |-> $past(state == ST_CAP_DR || state == ST_SH_DR
                                  || state == ST_EX2_DR)); // R1

endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output logic       sel_id,
  output logic       sel_bnd,
  output logic       sel_byp,
  output logic       upd_ok,
  output logic       op_drive,
  output logic       op_hiz
);

  logic [OP_W-1:0] shift_q;
  logic [OP_W-1:0] op_q;

  wire cap_en = (state == ST_CAP_IR);
  wire sh_en  = (state == ST_SH_IR);
  wire upd_en = (state == ST_UPD_IR);
  wire rst_en = (state == ST_RESET);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      shift_q <= '0;
    else if (cap_en) shift_q <= OP_CAPTURE_PATTERN;
    else if (sh_en)  shift_q <= {tdi, shift_q[OP_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_IDCODE;
    else if (rst_en) op_q <= OP_IDCODE;
    else if (upd_en) op_q <= shift_q;
  end

  assign ir_lsb = shift_q[0];

  always_comb begin
    sel_id = 1'b0; sel_bnd = 1'b0; sel_byp = 1'b0;
    upd_ok = 1'b0; op_drive = 1'b0; op_hiz = 1'b0;
    case (op_q)
      OP_EXTEST:  begin sel_bnd = 1'b1; upd_ok = 1'b1; op_drive = 1'b1; end
      OP_IDCODE:  sel_id = 1'b1;
      OP_SAMPLEZ: begin sel_bnd = 1'b1; op_hiz = 1'b1; end
      OP_SAMPLE:  begin sel_bnd = 1'b1; upd_ok = 1'b1; end
      default:    sel_byp = 1'b1;
    endcase
  end

  AST_RESET_GIVES_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (op_q == OP_IDCODE)); // R3

  AST_OP_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(op_q)); // R4

  AST_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (shift_q == OP_CAPTURE_PATTERN)); // R4

endmodule

// File: rtl/jtag_dr.sv
module jtag_dr
  import jtag_pkg::*;
#(
  parameter int unsigned BND_LEN = 107,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  logic               sel_id,
  input  logic               sel_bnd,
  input  logic               sel_byp,
  input  logic               upd_ok,
  input  logic [BND_LEN-1:0] pin_sample_i,
  output logic [BND_LEN-1:0] pin_drive_o,
  output logic               dr_lsb
);

  localparam int unsigned ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BND_LEN-1:0] bnd_q;
  logic [BND_LEN-1:0] upd_q;

  wire cap_en = (state == ST_CAP_DR);
  wire sh_en  = (state == ST_SH_DR);
  wire upd_en = (state == ST_UPD_DR) && upd_ok;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 byp_q <= 1'b0;
    else if (sel_byp && cap_en) byp_q <= 1'b0;
    else if (sel_byp && sh_en)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                id_q <= '0;
    else if (sel_id && cap_en) id_q <= ID_WORD;
    else if (sel_id && sh_en)  id_q <= {tdi, id_q[ID_W-1:1]};
  end

  generate
    if (BND_LEN > 1) begin : g_bnd_multi
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                 bnd_q <= '0;
        else if (sel_bnd && cap_en) bnd_q <= pin_sample_i;
        else if (sel_bnd && sh_en)  bnd_q <= {tdi, bnd_q[BND_LEN-1:1]};
      end
    end else begin : g_bnd_single
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                 bnd_q <= '0;
        else if (sel_bnd && cap_en) bnd_q <= pin_sample_i;
        else if (sel_bnd && sh_en)  bnd_q <= tdi;
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= bnd_q;
  end

  assign pin_drive_o = upd_q;

  always_comb begin
    if (sel_id)       dr_lsb = id_q[0];
    else if (sel_bnd) dr_lsb = bnd_q[0];
    else              dr_lsb = byp_q;
  end

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_en && sel_byp) |=> (dr_lsb == 1'b0)); // R6

  AST_ID_FIXED_BIT: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_en && sel_id) |=> (dr_lsb == 1'b1)); // R5

  AST_DRIVE_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    !(state == ST_UPD_DR && upd_ok) |=> $stable(pin_drive_o)); // R8

endmodule

// File: rtl/jtag_port.sv
module jtag_port
  import jtag_pkg::*;
#(
  parameter int unsigned BND_LEN   = 107,
  parameter logic [3:0]  ID_REV    = 4'h0,
  parameter logic [15:0] ID_PART   = 16'h0001,
  parameter logic [10:0] ID_VENDOR = 11'h001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [BND_LEN-1:0] pin_sample_i,
  output logic [BND_LEN-1:0] pin_drive_o,
  output logic               pin_drive_en,
  output logic               pin_hiz
);

  localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VENDOR, 1'b1};

  // Power-up reset: asserted at once, released on the second rising tck.
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e state;
  logic ir_lsb, dr_lsb;
  logic sel_id, sel_bnd, sel_byp, upd_ok, op_drive, op_hiz;

  jtag_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  jtag_ir u_ir (
    .tck      (tck),
    .rst_n    (rst_n),
    .tdi      (tdi),
    .state    (state),
    .ir_lsb   (ir_lsb),
    .sel_id   (sel_id),
    .sel_bnd  (sel_bnd),
    .sel_byp  (sel_byp),
    .upd_ok   (upd_ok),
    .op_drive (op_drive),
    .op_hiz   (op_hiz)
  );

  jtag_dr #(.BND_LEN(BND_LEN), .ID_WORD(ID_WORD)) u_dr (
    .tck          (tck),
    .rst_n        (rst_n),
    .tdi          (tdi),
    .state        (state),
    .sel_id       (sel_id),
    .sel_bnd      (sel_bnd),
    .sel_byp      (sel_byp),
    .upd_ok       (upd_ok),
    .pin_sample_i (pin_sample_i),
    .pin_drive_o  (pin_drive_o),
    .dr_lsb       (dr_lsb)
  );

  assign pin_drive_en = op_drive;
  assign pin_hiz      = op_hiz;

  // Serial output stage: retimed to the falling edge.
  wire in_sh_ir = (state == ST_SH_IR);
  wire in_sh_dr = (state == ST_SH_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_sh_ir | in_sh_dr;
      if (in_sh_ir)      tdo <= ir_lsb;
      else if (in_sh_dr) tdo <= dr_lsb;
    end
  end

  AST_TDO_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (in_sh_ir || in_sh_dr)); // R11

  AST_MODES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!rst_n)
    !(pin_hiz && pin_drive_en)); // R10

  AST_TDO_STEADY_AT_RISE: assert property (@(posedge tck) disable iff (!rst_n)
    $stable(tdo_en) || in_sh_ir || in_sh_dr || $past(in_sh_ir || in_sh_dr)); // R11

endmodule

// File: tb/test_jtag_port.sv
module test_jtag_port;

  localparam int unsigned BND = 20;
  localparam logic [3:0]  REV  = 4'h3;
  localparam logic [15:0] PART = 16'h01A5;
  localparam logic [10:0] VEND = 11'h2B4;
  localparam logic [31:0] IDW  = {REV, PART, VEND, 1'b1};

  logic           tck, por_n, tms, tdi;
  logic           tdo, tdo_en, pin_drive_en, pin_hiz;
  logic [BND-1:0] pin_sample_i, pin_drive_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  bit    exp_q[$];
  string tag_q[$];

  jtag_port #(.BND_LEN(BND), .ID_REV(REV), .ID_PART(PART), .ID_VENDOR(VEND)) i_jtag_port (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_sample_i(pin_sample_i), .pin_drive_o(pin_drive_o),
    .pin_drive_en(pin_drive_en), .pin_hiz(pin_hiz)
  );

  initial begin
    tck = 1'b0;
    forever #5 tck = ~tck;
  end

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one prediction for every valid serial output cycle.
  initial begin
    logic seen;
    forever begin
      @(negedge tck); #2;
      if (tdo_en) begin
        seen = tdo;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected tdo_en", 128'(tdo_en), 128'd0);
        end else begin
          automatic bit    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(tdo == e, t, 128'(tdo), 128'(e));
        end
        @(posedge tck); #1;
        chk(tdo == seen, "R11 tdo moved at rising edge", 128'(tdo), 128'(seen));
      end
    end
  end

  task automatic push(input bit e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(negedge tck); #2;
    @(posedge tck); #1;
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din,
                          input logic [127:0] exp, input string tag);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      push(exp[i], tag);
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] code);
    logic d0, h0;
    d0 = pin_drive_en; h0 = pin_hiz;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      push(i == 0, "R4 capture pattern 001");
      step(i == 2, code[i]);
    end
    chk(pin_drive_en == d0 && pin_hiz == h0, "R4 code not active before Update-IR",
        {pin_drive_en, pin_hiz}, {d0, h0});
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge tck);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, c, d, e;
    a = 128'(20'hA5C3E); b = 128'(20'h1F0E2); c = 128'(20'h6D2B9);
    d = 128'(20'h3C71A); e = 128'(20'h0F0F0);
    por_n = 1'b0; tms = 1'b1; tdi = 1'b0; pin_sample_i = '0;
    repeat (3) @(posedge tck);
    @(negedge tck); #2;
    chk(tdo_en == 1'b0, "R11 reset tdo_en", 128'(tdo_en), 0);
    chk(pin_drive_en == 1'b0 && pin_hiz == 1'b0, "R9 R10 reset modes",
        {pin_drive_en, pin_hiz}, 0);
    chk(pin_drive_o == '0, "R8 reset drive value", 128'(pin_drive_o), 0);
    por_n = 1'b1;
    @(posedge tck); #1;
    step(1, 0); step(1, 0); step(1, 0);
    step(0, 0);

    // IDCODE after power-up
    shift_dr(32, 128'h0, 128'(IDW), "R3 R5 idcode after power-up");

    // BYPASS
    load_ir(3'b111);
    shift_dr(8, 128'hB6, {120'h0, 8'h6C}, "R6 bypass delay");

    // Reserved code behaves as BYPASS
    load_ir(3'b101);
    shift_dr(8, 128'h39, {120'h0, 8'h72}, "R4 R6 reserved acts as bypass");

    // Pause loop during a bypass shift: tdi 1,0,1,1
    step(1, 0); step(0, 0); step(0, 0);
    push(0, "R1 pause path"); step(0, 1);
    push(1, "R1 pause path"); step(1, 0);
    step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    push(0, "R1 resume after pause"); step(0, 1);
    push(1, "R1 resume after pause"); step(1, 1);
    step(1, 0); step(0, 0);

    // SAMPLE/PRELOAD
    pin_sample_i = a[BND-1:0];
    load_ir(3'b100);
    chk(pin_drive_en == 0 && pin_hiz == 0, "R9 R10 preload modes", {pin_drive_en, pin_hiz}, 0);
    shift_dr(BND, b, a, "R7 sample capture");
    chk(pin_drive_o == b[BND-1:0], "R8 preload update", 128'(pin_drive_o), b);

    // EXTEST
    pin_sample_i = d[BND-1:0];
    load_ir(3'b000);
    chk(pin_drive_en == 1'b1, "R9 extest drive enable", 128'(pin_drive_en), 1);
    chk(pin_drive_o == b[BND-1:0], "R8 drive holds across IR load", 128'(pin_drive_o), b);
    shift_dr(BND, c, d, "R7 extest capture");
    chk(pin_drive_o == c[BND-1:0], "R8 extest update", 128'(pin_drive_o), c);

    // SAMPLE-Z
    pin_sample_i = e[BND-1:0];
    load_ir(3'b010);
    chk(pin_hiz == 1'b1 && pin_drive_en == 1'b0, "R10 R9 sample-z modes",
        {pin_drive_en, pin_hiz}, 1);
    shift_dr(BND, a, e, "R7 sample-z capture");
    chk(pin_drive_o == c[BND-1:0], "R8 sample-z leaves drive", 128'(pin_drive_o), c);

    // Five tms-high edges from Shift-DR under BYPASS
    load_ir(3'b111);
    step(1, 0); step(0, 0); step(0, 0);
    push(0, "R2 bypass bit before reset walk");
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    chk(pin_hiz == 0 && pin_drive_en == 0, "R2 R3 modes after tms reset",
        {pin_drive_en, pin_hiz}, 0);
    step(0, 0);
    shift_dr(32, 128'h0, 128'(IDW), "R2 R3 idcode after tms reset");

    step(0, 0);
    chk(exp_q.size() == 0, "R11 all predictions consumed", 128'(exp_q.size()), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule